// File: doc/BRIEF.md
# UART Register File and Interrupt Controller

This block is the bus-facing register file of a simple serial port. A 32-bit read/write port, addressed in bytes and decoded by word (`addr_i >> 2`), reaches the data register, the status flags, eight configuration registers (low-power divisor, integer and fractional baud divisor, line control, control, FIFO level select, interrupt mask, DMA control), the raw and masked interrupt status and an interrupt-clear register. A read-only identification window sits in the top 32 bytes of a 4 KiB region. Reads and write strobes complete in the cycle of the access. There are no wait states.

A data-register write hands the low byte to the transmit port and raises the transmit interrupt at once. Received bytes enter an internal FIFO. That FIFO is either `DEPTH` deep or a single holding slot, as line control selects. A data-register read pops the oldest byte. The receive interrupt is raised when a push brings the fill count up to a trigger level. It is dropped when a pop takes the count to one below that level. A single interrupt line is high whenever any unmasked raw bit is set.

Top module: `uart_regs`

## Requirements
- R1: After reset the flag register reads 0x90, raw status, mask and masked status read 0, `irq_o` is low and `rx_ready_o` is high.
- R2: Configuration registers at word indices 8, 9, 10, 11, 12, 13, 14 and 18 read back the last written value ANDed with 0xFF, 0xFFFF, 0x3F, 0xFF, 0xFFFF, 0x3F, 0x7FF and 0x7 respectively.
- R3: A write to word index 0 raises `tx_valid_o` in the same cycle with `tx_data_o` equal to `wdata_i[7:0]`. From the next cycle, raw status bit 5 (transmit) is set.
- R4: Masked status (index 16) reads raw status (index 15) AND mask (index 14). `irq_o` is high exactly when that value is nonzero.
- R5: A write to index 17 clears each raw status bit whose `wdata_i` bit is 1 and leaves the others unchanged.
- R6: Flag register (index 6) bits: 7 transmit empty (always 1), 6 receive full, 5 transmit full (always 0), 4 receive empty. Writes to it are accepted and change nothing.
- R7: With line control bit 4 set the receive FIFO holds `DEPTH` bytes, otherwise 1. `rx_ready_o` is high while the fill count is below that capacity. Flag bit 6 is its inverse, and bytes offered while it is low are dropped.
- R8: A read of index 0 returns the oldest received byte in bits 7:0 and removes it. The FIFO is first in, first out. On an empty FIFO the read returns 0 and changes nothing.
- R9: The receive trigger level is 1 when line control bit 4 is clear. Otherwise it is four times level-select bits 5:3, raised to 1 if zero and limited to `DEPTH`. It follows the current register values.
- R10: Raw status bit 4 (receive) is set when a push leaves the fill count equal to the trigger level. It is cleared when a data read leaves the count equal to the trigger level minus one.
- R11: A push and a data read in the same cycle both take effect: the count is unchanged and the order of bytes is kept. A read on an empty FIFO returns 0 while the pushed byte is kept.
- R12: Reads at byte offsets 0xFE0 to 0xFFC return one identification byte per word: 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 with `VARIANT`=0. With `VARIANT`=1 they are 0x11, 0x00, 0x18, 0x01, 0x0D, 0xF0, 0x05, 0xB1.
- R13: An undefined access raises `err_o` in that cycle, reads as 0 and, if a write, changes no register. Undefined accesses are: a read of index 1 to 5, 7, 17 or above 18 outside the window; a write of index 1 to 5, 7, 15, 16 or above 18; and any write to the identification window.
- R14: When an interrupt-clear write and a receive push that sets bit 4 fall in the same cycle, bit 4 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the 4 KiB region |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| err_o | output | 1 | Undefined access in this cycle |
| irq_o | output | 1 | Combined interrupt |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive FIFO can take a byte |

## Verification
The receive side and the bus run on separate ports, so a received byte can arrive in the same cycle as a bus access. The bench does this with a data-register read, which gives a push and a pop at one edge, at an empty FIFO, below the trigger and at it. It also does it with an interrupt-clear write, where the push must win the receive bit. A behavioural model with a byte queue predicts fill count, byte order and raw status for every cycle. Read data, `rx_ready_o` and `irq_o` are judged against that model, and the raw status read back afterwards shows the outcome of each collision.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned INT_W = 11;

  // word indices with fixed behaviour
  localparam int unsigned IX_DATA = 0;
  localparam int unsigned IX_FLAG = 6;
  localparam int unsigned IX_RAW  = 15;
  localparam int unsigned IX_MST  = 16;
  localparam int unsigned IX_ICLR = 17;

  // plain read/write configuration registers
  localparam int unsigned NCFG = 8;
  localparam int unsigned CFG_IDX [NCFG] = '{8, 9, 10, 11, 12, 13, 14, 18};
  localparam logic [31:0] CFG_MASK [NCFG] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF,
                                              32'hFFFF, 32'h3F, 32'h7FF, 32'h7};
  localparam int unsigned SLOT_LINE = 3;
  localparam int unsigned SLOT_LVL  = 5;
  localparam int unsigned SLOT_MASK = 6;

  localparam int unsigned LINE_FIFO_EN = 4;
  localparam int unsigned INT_RX = 4;
  localparam int unsigned INT_TX = 5;
  localparam int unsigned FLG_RXE = 4;
  localparam int unsigned FLG_RXF = 6;
  localparam int unsigned FLG_TXE = 7;

  function automatic logic [7:0] id_byte(input int unsigned variant, input logic [2:0] k);
    logic alt;
    alt = (variant != 0);
    case (k)
      3'd0:    id_byte = 8'h11;
      3'd1:    id_byte = alt ? 8'h00 : 8'h10;
      3'd2:    id_byte = alt ? 8'h18 : 8'h14;
      3'd3:    id_byte = alt ? 8'h01 : 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= inc(wp_q);
      if (pop_i)  rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_reg_decode.sv
module uart_reg_decode import uart_regs_pkg::*; #(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned WIX_W = ADDR_W - 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WIX_W-1:0]  idx_o,
  output logic              id_hit_o,
  output logic [2:0]        id_sel_o,
  output logic              defined_o
);
  logic cfg_hit, rd_ok, wr_ok;

  assign idx_o    = WIX_W'(addr_i >> 2);
  assign id_hit_o = &addr_i[ADDR_W-1:5];
  assign id_sel_o = idx_o[2:0];

  always_comb begin
    cfg_hit = 1'b0;
    for (int g = 0; g < NCFG; g++)
      if (32'(idx_o) == CFG_IDX[g]) cfg_hit = 1'b1;
    rd_ok = cfg_hit || 32'(idx_o) == IX_DATA || 32'(idx_o) == IX_FLAG
            || 32'(idx_o) == IX_RAW || 32'(idx_o) == IX_MST;
    wr_ok = cfg_hit || 32'(idx_o) == IX_DATA || 32'(idx_o) == IX_FLAG
            || 32'(idx_o) == IX_ICLR;
    if (id_hit_o) defined_o = !we_i;
    else          defined_o = we_i ? wr_ok : rd_ok;
  end
endmodule

// File: rtl/uart_irq.sv
module uart_irq import uart_regs_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] mask_i,
  input  logic             clr_we_i,
  input  logic [INT_W-1:0] clr_val_i,
  input  logic             tx_set_i,
  input  logic             rx_set_i,
  input  logic             rx_clr_i,
  output logic [INT_W-1:0] raw_o,
  output logic [INT_W-1:0] masked_o,
  output logic             irq_o
);
  logic [INT_W-1:0] raw_q, raw_d;

  // clears first, sets last: a set in the same cycle wins
  always_comb begin
    raw_d = raw_q;
    if (rx_clr_i) raw_d[INT_RX] = 1'b0;
    if (clr_we_i) raw_d = raw_d & ~clr_val_i;
    if (tx_set_i) raw_d[INT_TX] = 1'b1;
    if (rx_set_i) raw_d[INT_RX] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/uart_regs.sv
module uart_regs import uart_regs_pkg::*; #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned VARIANT = 0,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned WIX_W  = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o
);
  logic [WIX_W-1:0] idx;
  logic             id_hit, defined, wr_acc, rd_acc;
  logic [2:0]       id_sel;
  logic [31:0]      cfg_q [NCFG];
  logic [INT_W-1:0] mask_st, raw_st, masked_st;
  logic [CNT_W-1:0] rx_cnt, nxt_cnt, cap, trig;
  logic [7:0]       rx_head, flags;
  logic             fifo_en, push, pop, data_rd;
  int unsigned      lvl_t;
  logic [31:0]      rd_mux;

  uart_reg_decode #(.ADDR_W(ADDR_W)) i_dec (
    .we_i(we_i), .addr_i(addr_i), .idx_o(idx),
    .id_hit_o(id_hit), .id_sel_o(id_sel), .defined_o(defined)
  );

  assign wr_acc = req_i && we_i && defined;
  assign rd_acc = req_i && !we_i && defined;
  assign err_o  = req_i && !defined;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[g] <= '0;
      else if (wr_acc && 32'(idx) == CFG_IDX[g])
        cfg_q[g] <= wdata_i & CFG_MASK[g];
    end
  end

  assign mask_st = cfg_q[SLOT_MASK][INT_W-1:0];
  assign fifo_en = cfg_q[SLOT_LINE][LINE_FIFO_EN];
  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

  // trigger level follows the live line-control and level-select values
  always_comb begin
    lvl_t = 32'(cfg_q[SLOT_LVL][5:3]) << 2;
    if (lvl_t == 0)     lvl_t = 1;
    if (lvl_t > DEPTH)  lvl_t = DEPTH;
    trig = fifo_en ? CNT_W'(lvl_t) : CNT_W'(1);
  end

  assign rx_ready_o = rx_cnt < cap;
  assign data_rd    = rd_acc && !id_hit && 32'(idx) == IX_DATA;
  assign push       = rx_valid_i && rx_ready_o;
  assign pop        = data_rd && rx_cnt != '0;
  assign nxt_cnt    = rx_cnt + CNT_W'(push) - CNT_W'(pop);

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .wdata_i(rx_data_i), .rdata_o(rx_head), .count_o(rx_cnt)
  );

  assign tx_valid_o = wr_acc && 32'(idx) == IX_DATA;
  assign tx_data_o  = wdata_i[7:0];

  uart_irq i_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(mask_st),
    .clr_we_i(wr_acc && 32'(idx) == IX_ICLR),
    .clr_val_i(wdata_i[INT_W-1:0]),
    .tx_set_i(tx_valid_o),
    .rx_set_i(push && nxt_cnt == trig),
    .rx_clr_i(pop && nxt_cnt == trig - 1'b1),
    .raw_o(raw_st), .masked_o(masked_st), .irq_o(irq_o)
  );

  always_comb begin
    flags          = '0;
    flags[FLG_TXE] = 1'b1;
    flags[FLG_RXF] = !rx_ready_o;
    flags[FLG_RXE] = rx_cnt == '0;
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) rd_mux = {24'b0, id_byte(VARIANT, id_sel)};
    else begin
      if (32'(idx) == IX_DATA && rx_cnt != '0) rd_mux = {24'b0, rx_head};
      if (32'(idx) == IX_FLAG) rd_mux = {24'b0, flags};
      if (32'(idx) == IX_RAW)  rd_mux = 32'(raw_st);
      if (32'(idx) == IX_MST)  rd_mux = 32'(masked_st);
      for (int g = 0; g < NCFG; g++)
        if (32'(idx) == CFG_IDX[g]) rd_mux = cfg_q[g];
    end
  end

  assign rdata_o = rd_acc ? rd_mux : '0;
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-3:0] widx_i,
  input logic [10:0]       icr_wd_i,
  input logic [31:0]       rdata_i,
  input logic              err_i,
  input logic              irq_i,
  input logic              rx_valid_i,
  input logic              rx_ready_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [10:0]       raw_i,
  input logic [10:0]       mask_i
);
  AST_TX_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx_i == 0) |=> raw_i[5]); // R3
  AST_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && widx_i == 16) |-> (irq_i == (rdata_i != 0))); // R4
  AST_ICR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx_i == 17 && !rx_valid_i) |=> ((raw_i & $past(icr_wd_i)) == 0)); // R5
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) <= DEPTH); // R7
  AST_NOT_READY_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i |-> cnt_i != 0); // R7
  AST_PUSH_POP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_i && req_i && !we_i && widx_i == 0 && cnt_i != 0)
    |=> $stable(cnt_i)); // R11
  AST_ERR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !we_i) |-> rdata_i == 0); // R13
  AST_ERR_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && we_i) |=> $stable(mask_i)); // R13
endmodule

bind uart_regs uart_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .widx_i(addr_i[ADDR_W-1:2]), .icr_wd_i(wdata_i[10:0]), .rdata_i(rdata_o),
  .err_i(err_o), .irq_i(irq_o), .rx_valid_i(rx_valid_i), .rx_ready_i(rx_ready_o),
  .cnt_i(rx_cnt), .raw_i(raw_st), .mask_i(mask_st)
);

// File: tb/test_uart_regs.sv
module test_uart_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, rxv = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  rxd = '0;
  logic [31:0] rdata;
  logic        err, irq, txv, rxr;
  logic [7:0]  txd;

  int n_chk = 0, n_err = 0;

  // reference model state
  byte unsigned q[$];
  logic [31:0]  reg_m [32];
  logic [10:0]  raw_m;

  always #10 clk = ~clk;

  uart_regs i_uart_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq),
    .tx_valid_o(txv), .tx_data_o(txd), .rx_valid_i(rxv), .rx_data_i(rxd),
    .rx_ready_o(rxr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int ix);
    case (ix)
      8, 11:   return 32'hFF;
      9, 12:   return 32'hFFFF;
      10, 13:  return 32'h3F;
      14:      return 32'h7FF;
      18:      return 32'h7;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int cap_m();
    return reg_m[11][4] ? 16 : 1;
  endfunction

  function automatic int trig_m();
    int t;
    if (!reg_m[11][4]) return 1;
    t = int'(reg_m[13][5:3]) * 4;
    if (t == 0) t = 1;
    if (t > 16) t = 16;
    return t;
  endfunction

  function automatic logic exp_err(input logic [11:0] a, input logic w);
    int ix = int'(a >> 2);
    if (a[11:5] == 7'h7F) return w;
    if (w) return !(ix == 0 || ix == 6 || wmask(ix) != 0 || ix == 17);
    return !(ix == 0 || ix == 6 || wmask(ix) != 0 || ix == 15 || ix == 16);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int ix = int'(a >> 2);
    logic [7:0] idt [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a[11:5] == 7'h7F) return {24'b0, idt[a[4:2]]};
    if (exp_err(a, 1'b0)) return 32'h0;
    if (ix == 0) return (q.size() > 0) ? {24'b0, q[0]} : 32'h0;
    if (ix == 6) return 32'h80 | ((q.size() >= cap_m()) ? 32'h40 : 0) | ((q.size() == 0) ? 32'h10 : 0);
    if (ix == 15) return {21'b0, raw_m};
    if (ix == 16) return {21'b0, raw_m & reg_m[14][10:0]};
    return reg_m[ix];
  endfunction

  task automatic model_step(input logic rq, input logic w, input logic [11:0] a,
                            input logic [31:0] d, input logic rv, input logic [7:0] rb);
    int ix = int'(a >> 2);
    logic bad = rq && exp_err(a, w);
    logic ps = rv && (q.size() < cap_m());
    logic pp = rq && !w && !bad && a[11:5] != 7'h7F && ix == 0 && q.size() > 0;
    int t = trig_m();
    int n;
    if (pp) void'(q.pop_front());
    if (ps) q.push_back(rb);
    n = q.size();
    if (pp && n == t - 1) raw_m[4] = 1'b0;
    if (rq && w && !bad) begin
      if (ix == 17) raw_m = raw_m & ~d[10:0];
      if (ix == 0)  raw_m[5] = 1'b1;
      if (wmask(ix) != 0) reg_m[ix] = d & wmask(ix);
    end
    if (ps && n == t) raw_m[4] = 1'b1;
  endtask

  task automatic cyc(input logic rq, input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic rv, input logic [7:0] rb, input string tag);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; rxv = rv; rxd = rb;
    #2;
    check("R4", "irq_o", 32'(irq), 32'(|(raw_m & reg_m[14][10:0])));
    check("R7", "rx_ready_o", 32'(rxr), 32'(q.size() < cap_m()));
    if (rq) check("R13", "err_o", 32'(err), 32'(exp_err(a, w)));
    if (rq && !w) check(tag, $sformatf("read %0h", a), rdata, model_read(a));
    if (rq && w && !exp_err(a, w) && (a >> 2) == 0) begin
      check("R3", "tx_valid_o", 32'(txv), 32'd1);
      check("R3", "tx_data_o", 32'(txd), 32'(d[7:0]));
    end else check("R3", "tx_valid_o idle", 32'(txv), 32'd0);
    @(posedge clk);
    model_step(rq, w, a, d, rv, rb);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 8'h0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h0, tag);
  endtask
  task automatic push(input logic [7:0] b, input string tag);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, b, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [11:0] cfg_a [8] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h038, 12'h048};
    for (int i = 0; i < 32; i++) reg_m[i] = '0;
    raw_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 8'h0, "R1");
    rd(12'h018, "R1"); rd(12'h03C, "R1"); rd(12'h038, "R1"); rd(12'h040, "R1");

    // R2 config readback with field widths
    for (int i = 0; i < 8; i++) begin
      wr(cfg_a[i], 32'hFFFF_FFFF, "R2"); rd(cfg_a[i], "R2");
      wr(cfg_a[i], 32'h1234_5678, "R2"); rd(cfg_a[i], "R2");
      wr(cfg_a[i], 32'h0, "R2");
    end

    // R6 flag write ignored
    wr(12'h018, 32'hFFFF_FFFF, "R6"); rd(12'h018, "R6");

    // R3 / R4 transmit and masking
    wr(12'h038, 32'h20, "R4");
    wr(12'h000, 32'h1A5, "R3");
    rd(12'h03C, "R3"); rd(12'h040, "R4");
    wr(12'h038, 32'h0, "R4"); rd(12'h040, "R4");
    wr(12'h038, 32'h30, "R4");

    // R5 write-one-to-clear
    wr(12'h044, 32'h0, "R5"); rd(12'h03C, "R5");
    wr(12'h044, 32'hFFFF_FFDF, "R5"); rd(12'h03C, "R5");
    wr(12'h044, 32'h20, "R5"); rd(12'h03C, "R5");

    // R7 / R8 / R10 single-slot mode
    push(8'h41, "R7"); push(8'h42, "R7");
    rd(12'h018, "R7"); rd(12'h03C, "R10");
    rd(12'h000, "R8"); rd(12'h03C, "R10");
    rd(12'h000, "R8"); rd(12'h018, "R8");

    // R9 / R10 FIFO mode, trigger 8
    wr(12'h02C, 32'h10, "R9"); wr(12'h034, 32'h10, "R9");
    for (int i = 0; i < 7; i++) push(8'(8'h60 + i), "R9");
    rd(12'h03C, "R9");
    push(8'h67, "R10"); rd(12'h03C, "R10");
    for (int i = 8; i < 18; i++) push(8'(8'h60 + i), "R7");
    rd(12'h018, "R7");
    for (int i = 0; i < 9; i++) rd(12'h000, "R8");
    rd(12'h03C, "R10");

    // R11 push and pop together
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 12'h000, 32'h0, 1'b1, 8'(8'hC0 + i), "R11");
    push(8'hD0, "R11");
    cyc(1'b1, 1'b0, 12'h000, 32'h0, 1'b1, 8'hD1, "R11");
    rd(12'h03C, "R11");
    for (int i = 0; i < 10; i++) rd(12'h000, "R11");
    cyc(1'b1, 1'b0, 12'h000, 32'h0, 1'b1, 8'h5A, "R11");
    rd(12'h000, "R11");

    // R9 other levels: zero field gives 1, large field clamps to depth
    wr(12'h044, 32'h7FF, "R9");
    wr(12'h034, 32'h00, "R9"); push(8'h11, "R9"); rd(12'h03C, "R9");
    rd(12'h000, "R9"); rd(12'h03C, "R9");
    wr(12'h034, 32'h38, "R9");
    for (int i = 0; i < 15; i++) push(8'(i), "R9");
    rd(12'h03C, "R9");
    push(8'hEE, "R10"); rd(12'h03C, "R10");
    for (int i = 0; i < 16; i++) rd(12'h000, "R8");

    // R14 clear and push collide
    wr(12'h02C, 32'h0, "R14"); wr(12'h044, 32'h7FF, "R14");
    cyc(1'b1, 1'b1, 12'h044, 32'h10, 1'b1, 8'h77, "R14");
    rd(12'h03C, "R14"); rd(12'h000, "R14");

    // R12 identification window
    for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(4 * k), "R12");

    // R13 undefined accesses
    rd(12'h004, "R13"); rd(12'h01C, "R13"); rd(12'h044, "R13"); rd(12'h100, "R13");
    wr(12'h03C, 32'hFFFF_FFFF, "R13"); wr(12'h040, 32'hFFFF_FFFF, "R13");
    wr(12'hFE0, 32'hFFFF_FFFF, "R13"); wr(12'h01C, 32'hFFFF_FFFF, "R13");
    wr(12'h400, 32'hFFFF_FFFF, "R13");
    rd(12'h038, "R13"); rd(12'h03C, "R13"); rd(12'h02C, "R13");

    cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 8'h0, "R1");
    summary();
  end
endmodule